// File: doc/BRIEF.md
# Per-Line Input Debounce Filter Bank

This block cleans up a group of external interrupt input lines before they reach the edge and level detection logic. Each line first passes through a two-stage synchroniser. The line then feeds a stability filter that lets the synchronised value through only after it has stayed unchanged for a chosen time. Lines at or above the `DBNC_LINES` parameter have no filter. A line that is not marked level-sensitive, that is disabled, or that selects an unused time index also has no filter. All of these lines simply track their synchronised input.

Software reaches the controls through a small synchronous register bus. Each line has an 8-bit control byte holding three things:
- an enable bit;
- a counter-restart bit that clears itself;
- a 4-bit index into a fixed table of durations in microseconds.

Four control bytes share a 32-bit word. Software can read the words, and it changes them only through a set alias and a clear alias, so no read-modify-write is needed. A prescaler turns the system clock into a microsecond tick (`TICK_CYCLES` clocks per tick). The stability counter counts these ticks and stops at the selected limit.

Top module: `line_debounce_bank`

## Requirements
- R1: After reset every control bit reads as 0, and every `line_out` bit follows its `line_in` bit 3 clock cycles after the input is driven.
- R2: Line n owns byte lane n mod 4 of word n/4. Words are readable at byte address 0x500 + 4*(n/4). Within a byte, bit 0 is enable, bit 1 is counter restart, bits 7:4 are the time index, and bits 3:2 always read 0. Read data appears on `bus_rdata` one cycle after `bus_rd`, and is 0 otherwise.
- R3: A write to 0x600 + 4*w ORs the written ones into word w. A write to 0x700 + 4*w clears the bits written as one. All other bits keep their value.
- R4: Indices 0 to 9 select 125, 250, 500, 1000, 16000, 32000, 64000, 128000, 256000 and 512000 µs. Indices 10 to 15 disable filtering, so the line follows its input after 3 cycles.
- R5: A line is filtered only when its enable bit is 1, its index is below `DBNC_LINES`, and `line_level` for that line is 1. In every other case it follows its input after 3 cycles.
- R6: On a filtered line with one tick per clock and a duration of N µs, `line_out` changes N+4 cycles after the input is driven, provided the input then stays stable. A pulse shorter than N ticks never reaches `line_out`.
- R7: The restart bit reads back as 0 two cycles after it is set. It empties the stability count within 2 cycles, so `line_out` changes N+3 cycles after the write when the write follows an input change. A restart written in the same cycle as an input change leaves the latency at N+4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after `bus_rd` |
| line_level | input | NUM_LINES | 1 = line is level-sensitive, so filtering is allowed |
| line_in | input | NUM_LINES | Raw asynchronous input lines |
| line_out | output | NUM_LINES | Filtered or passed-through lines |

## Verification
A counter restart written through the set alias can land in the same cycle as an input change that the filter is about to see. The bench toggles a filtered line and issues the restart write on the same clock edge. It then expects the output to move exactly N+4 cycles later, as it would for a plain change, and neither earlier nor later. A separate case applies the restart well after the change and expects the latency to be measured from the write instead.

// File: rtl/dbnc_pkg.sv
package dbnc_pkg;
  localparam int CNT_W   = 20;
  localparam int IDX_W   = 4;
  localparam logic [3:0] RGN_READ = 4'h5;
  localparam logic [3:0] RGN_SET  = 4'h6;
  localparam logic [3:0] RGN_CLR  = 4'h7;
  localparam int B_EN    = 0;
  localparam int B_RST   = 1;
  localparam int IDX_LSB = 4;

  // Duration in microsecond ticks; 0 means the index is unused (no filtering).
  function automatic logic [CNT_W-1:0] dur_ticks(input logic [IDX_W-1:0] idx);
    case (idx)
      4'd0:    dur_ticks = CNT_W'(125);
      4'd1:    dur_ticks = CNT_W'(250);
      4'd2:    dur_ticks = CNT_W'(500);
      4'd3:    dur_ticks = CNT_W'(1000);
      4'd4:    dur_ticks = CNT_W'(16000);
      4'd5:    dur_ticks = CNT_W'(32000);
      4'd6:    dur_ticks = CNT_W'(64000);
      4'd7:    dur_ticks = CNT_W'(128000);
      4'd8:    dur_ticks = CNT_W'(256000);
      4'd9:    dur_ticks = CNT_W'(512000);
      default: dur_ticks = '0;
    endcase
  endfunction
endpackage

// File: rtl/dbnc_ctrl_regs.sv
module dbnc_ctrl_regs
  import dbnc_pkg::*;
#(
  parameter int NUM_LINES = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [11:0]                bus_addr,
  input  logic [31:0]                bus_wdata,
  output logic [31:0]                bus_rdata,
  output logic [NUM_LINES-1:0]       cfg_en,
  output logic [NUM_LINES-1:0]       cfg_crst,
  output logic [NUM_LINES*IDX_W-1:0] cfg_idx
);
  logic [3:0] region;
  logic [5:0] word_sel;
  logic       aligned, set_wr, clr_wr;
  logic [31:0] rd_mux;
  logic       unused_bits;

  assign region   = bus_addr[11:8];
  assign word_sel = bus_addr[7:2];
  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign set_wr   = bus_wr && aligned && (region == RGN_SET);
  assign clr_wr   = bus_wr && aligned && (region == RGN_CLR);
  assign unused_bits = ^(bus_wdata & 32'h0C0C_0C0C);

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    localparam int         LANE = l % 4;
    localparam logic [5:0] WSEL = 6'(l / 4);
    logic             hit, en_q, crst_q;
    logic [IDX_W-1:0] idx_q, w_idx;
    logic             w_en, w_rst;

    assign hit   = (word_sel == WSEL);
    assign w_en  = bus_wdata[8*LANE + B_EN];
    assign w_rst = bus_wdata[8*LANE + B_RST];
    assign w_idx = bus_wdata[8*LANE + IDX_LSB +: IDX_W];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q   <= 1'b0;
        crst_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        crst_q <= set_wr && hit && w_rst;   // lives for one cycle only
        if (set_wr && hit) begin
          en_q  <= en_q | w_en;
          idx_q <= idx_q | w_idx;
        end else if (clr_wr && hit) begin
          en_q  <= en_q & ~w_en;
          idx_q <= idx_q & ~w_idx;
        end
      end
    end

    assign cfg_en[l]                = en_q;
    assign cfg_crst[l]              = crst_q;
    assign cfg_idx[IDX_W*l +: IDX_W] = idx_q;

    // R7: a restart request never survives past one cycle without a new write
    assert_crst_selfclear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (crst_q && !$past(set_wr && hit && w_rst)) |=> !crst_q);
  end

  always_comb begin
    rd_mux = '0;
    for (int l = 0; l < NUM_LINES; l++) begin
      if (word_sel == 6'(l / 4))
        rd_mux[8*(l%4) +: 8] = {cfg_idx[IDX_W*l +: IDX_W], 2'b00, cfg_crst[l], cfg_en[l]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      bus_rdata <= '0;
    else
      bus_rdata <= (bus_rd && aligned && region == RGN_READ) ? rd_mux : '0;
  end

  // R2: reserved bit pairs read back as zero
  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & 32'h0C0C_0C0C) == 32'h0);
endmodule

// File: rtl/dbnc_tick_gen.sv
module dbnc_tick_gen #(
  parameter int TICK_CYCLES = 50
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  if (TICK_CYCLES <= 1) begin : g_every
    assign tick = 1'b1;
  end else begin : g_div
    localparam int PRE_W = $clog2(TICK_CYCLES);
    localparam logic [PRE_W-1:0] LAST = PRE_W'(TICK_CYCLES - 1);
    logic [PRE_W-1:0] pre_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             pre_q <= '0;
      else if (pre_q == LAST) pre_q <= '0;
      else                    pre_q <= pre_q + 1'b1;
    end
    assign tick = (pre_q == LAST);

    // R6: ticks are spaced apart when the divider is active
    assert_tick_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
  end
endmodule

// File: rtl/dbnc_line_filter.sv
module dbnc_line_filter #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             din,
  input  logic             active,
  input  logic             crst,
  input  logic [CNT_W-1:0] limit,
  output logic             dout
);
  logic             meta_q, sync_q, last_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= 1'b0;
      cnt_q  <= '0;
      dout   <= 1'b0;
    end else begin
      last_q <= sync_q;
      if (!active) begin
        cnt_q <= '0;
        dout  <= sync_q;
      end else begin
        if (sync_q != last_q || crst)
          cnt_q <= '0;
        else if (tick && cnt_q < limit)
          cnt_q <= cnt_q + 1'b1;
        if (sync_q == last_q && !crst && cnt_q >= limit)
          dout <= last_q;
      end
    end
  end

  // R5: an inactive filter hands the synchronised value straight on
  assert_bypass_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (dout == $past(sync_q)));
  // R6: a filtered output only moves once the count has reached the limit
  assert_hold_until_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !$stable(dout)) |-> ($past(cnt_q) >= $past(limit)));
  // R7: a restart empties the stability count on the next edge
  assert_crst_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && crst) |=> (cnt_q == '0));
endmodule

// File: rtl/line_debounce_bank.sv
module line_debounce_bank
  import dbnc_pkg::*;
#(
  parameter int NUM_LINES   = 8,
  parameter int DBNC_LINES  = 6,
  parameter int TICK_CYCLES = 50
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [11:0]          bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_LINES-1:0] line_level,
  input  logic [NUM_LINES-1:0] line_in,
  output logic [NUM_LINES-1:0] line_out
);
  logic [NUM_LINES-1:0]       cfg_en, cfg_crst;
  logic [NUM_LINES*IDX_W-1:0] cfg_idx;
  logic                       tick;

  dbnc_ctrl_regs #(.NUM_LINES(NUM_LINES)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cfg_en(cfg_en), .cfg_crst(cfg_crst), .cfg_idx(cfg_idx)
  );

  dbnc_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_filt
    localparam bit CAN_FILTER = (l < DBNC_LINES);
    logic [CNT_W-1:0] limit;
    logic             active;

    assign limit  = dur_ticks(cfg_idx[IDX_W*l +: IDX_W]);
    assign active = CAN_FILTER && cfg_en[l] && line_level[l] && (limit != '0);

    dbnc_line_filter #(.CNT_W(CNT_W)) u_filt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .din(line_in[l]),
      .active(active), .crst(cfg_crst[l]), .limit(limit), .dout(line_out[l])
    );
  end
endmodule

// File: tb/line_debounce_bank_tb.sv
module line_debounce_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_wr, bus_rd;
  logic [11:0]   bus_addr;
  logic [31:0]   bus_wdata, bus_rdata;
  logic [NL-1:0] line_level, line_in, line_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  line_debounce_bank #(.NUM_LINES(NL), .DBNC_LINES(6), .TICK_CYCLES(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .line_level(line_level), .line_in(line_in), .line_out(line_out)
  );

  typedef struct {
    int    line;
    logic  val;
    int    stamp;
    int    lat;
    string tag;
  } exp_t;

  exp_t          exp_q[$];
  int            cyc = 0;
  int            n_checks = 0;
  int            n_errors = 0;
  logic [NL-1:0] prev_out;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
  endtask

  // monitor: pops expected transitions as outputs move
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < NL; i++) begin
        if (line_out[i] != prev_out[i]) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R6", $sformatf("unexpected move on line %0d", i), line_out[i], prev_out[i]);
          end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.line == i, e.tag, "line that moved", i, e.line);
            check(line_out[i] == e.val, e.tag, "output value", line_out[i], e.val);
            check(cyc - e.stamp == e.lat, e.tag, "latency", cyc - e.stamp, e.lat);
          end
        end
      end
      prev_out = line_out;
    end else begin
      prev_out = '0;
    end
  end

  // all tasks start and end just after a falling edge
  task automatic drive(input int l, input logic v, input int lat, input string tag);
    exp_t e;
    e.line = l; e.val = v; e.stamp = cyc; e.lat = lat; e.tag = tag;
    exp_q.push_back(e);
    line_in[l] = v;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] expv, input string tag);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    check(bus_rdata == expv, tag, $sformatf("read 0x%0h", a), bus_rdata, expv);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", "run did not finish", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    line_level = '0; line_in = '0;
    idle(4);
    rst_n = 1'b1;
    idle(1);

    // R1: reset state and pass-through
    rd(12'h500, 32'h0, "R1");
    rd(12'h504, 32'h0, "R1");
    drive(4, 1'b1, 3, "R1");
    idle(6);

    // R2/R3: set alias with reserved bits also written
    wr(12'h600, 32'h11C1_1101 | 32'h0C0C_0C0C);
    rd(12'h500, 32'h11C1_1101, "R2");
    wr(12'h604, 32'h0001_0000);
    rd(12'h504, 32'h0001_0000, "R3");
    line_level = 8'b0100_1101;

    // R6: index 0 = 125 us on line 0
    drive(0, 1'b1, 125 + 4, "R6");
    idle(140);

    // R5: enabled but edge-sensitive line 1
    drive(1, 1'b1, 3, "R5");
    idle(6);
    // R5: line 6 is above the filtered range
    drive(6, 1'b1, 3, "R5");
    idle(6);
    // R4: unused index 12 on line 2
    drive(2, 1'b1, 3, "R4");
    idle(6);
    // R4: index 1 = 250 us on line 3
    drive(3, 1'b1, 250 + 4, "R4");
    idle(260);

    // R6: short glitch on line 0 must be swallowed
    line_in[0] = 1'b0;
    idle(60);
    line_in[0] = 1'b1;
    idle(200);
    check(line_out[0] == 1'b1, "R6", "line 0 after glitch", line_out[0], 1);
    check(exp_q.size() == 0, "R6", "pending after glitch", exp_q.size(), 0);

    // R7: restart 50 cycles after an input change
    drive(0, 1'b0, 50 + 125 + 3, "R7");
    idle(50);
    wr(12'h600, 32'h0000_0002);
    idle(1);
    rd(12'h500, 32'h11C1_1101, "R7");
    idle(200);

    // R3: clear alias removes line 1 byte only
    wr(12'h700, 32'h0000_FF00);
    rd(12'h500, 32'h11C1_0001, "R3");

    // R7: restart in the same cycle as an input change
    drive(3, 1'b0, 250 + 4, "R7");
    wr(12'h600, 32'h0200_0000);
    idle(270);

    // R5: disabling line 0 returns it to pass-through
    wr(12'h700, 32'h0000_0001);
    drive(0, 1'b1, 3, "R5");
    idle(8);

    check(exp_q.size() == 0, "R6", "pending at end", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule